// File: doc/BRIEF.md
# Write-After-Read Hazard Detector

This block sits beside a non-blocking cache that keeps pending reads and pending line fills in two separate in-order queues. Several reads can be outstanding at once, so a fill that returns from memory may target a cache line that queued reads still need. The detector takes three inputs: the valid bits and cache indices of every read-queue slot, the head entry of the write queue, and the read-queue pop strobe. From these it decides whether writing that fill now would evict data that an older read has not yet consumed.

Each write-queue entry carries the read-queue slot of the read whose miss caused it. A read-queue slot raises its hazard bit when four conditions all hold: the slot is valid, its index equals the index of the fill, it sits strictly ahead of that miss slot in arrival order, and it is not completing in the current cycle. Arrival order is measured from a read-queue head pointer. The detector keeps this pointer itself, moving it on each pop, so age comparisons stay correct when the ring wraps. The hazard bits are ORed into one stall output. This output is combinational, so the fill can be written in the same cycle in which the last conflicting read pops.

The index width is derived from the cache size, line size and associativity parameters. The queue depth is a parameter.

Top module: `war_hazard_guard`

## Requirements
- R1: A reset (synchronous, active high) sets the read-queue head pointer to slot 0, so slot 0 is the oldest slot afterwards.
- R2: A slot whose index differs from the write-queue head index never raises its hazard bit.
- R3: A slot whose valid bit is 0 never raises its hazard bit.
- R4: A valid slot with a matching index raises its hazard bit when its age is less than the age of the recorded miss slot. A slot's age is (slot - head) mod DEPTH, and the comparison is correct across ring wrap.
- R5: The recorded miss slot, and every slot younger than it, never raises a hazard bit.
- R6: When the write-queue head is not valid, all hazard bits and the stall output are 0.
- R7: stall_write is 1 exactly when at least one hazard bit is 1, in the same cycle.
- R8: While rd_pop is 1, the head slot's hazard bit is 0. This lets the fill proceed in the cycle its last conflicting read completes.
- R9: Each clock edge with rd_pop at 1 advances the head pointer by one slot modulo DEPTH. Without rd_pop the head pointer holds.
- R10: When the recorded miss slot equals the head slot, no hazard bit is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rq_valid | input | DEPTH | Valid bit of each read-queue slot |
| rq_index | input | DEPTH*IDX_W | Cache index of each slot; slot i occupies bits [i*IDX_W +: IDX_W] |
| rd_pop | input | 1 | The read at the head completes this cycle |
| wq_valid | input | 1 | The write-queue head holds a pending fill |
| wq_index | input | IDX_W | Cache index of the pending fill |
| wq_slot | input | PTR_W | Read-queue slot of the read whose miss caused the fill |
| hazard | output | DEPTH | Per-slot hazard bits |
| stall_write | output | 1 | Hold off the fill write |

## Verification
The bench sweeps a four-slot configuration through every pattern of valid bits, miss slot, fill index and pop strobe. The slot indices are pseudo-random, and the pops move the head through every wrap position. The expected bits come from walking the ring forward from the head. A design that compares raw slot numbers instead of ages would flag the wrong slots once the head has wrapped. A design that includes the miss slot would stall the fill forever on its own read. A design that leaves out the pop mask would hold the fill one cycle too long. Directed cases check that reset places the head at slot 0 and that a run of pops moves it one slot each time.

// File: rtl/war_hazard_pkg.sv
package war_hazard_pkg;

  // Position of a slot counted from the oldest entry of a ring of depth slots.
  function automatic int unsigned ring_age(input int unsigned slot,
                                           input int unsigned head,
                                           input int unsigned depth);
    return (slot + depth - head) % depth;
  endfunction

  // True when slot a was queued before slot b.
  function automatic logic queued_before(input int unsigned a,
                                         input int unsigned b,
                                         input int unsigned head,
                                         input int unsigned depth);
    return ring_age(a, head, depth) < ring_age(b, head, depth);
  endfunction

  // Set count of a cache built from its byte size, line size and associativity.
  function automatic int unsigned set_count(input int unsigned cache_bytes,
                                            input int unsigned line_bytes,
                                            input int unsigned ways);
    return cache_bytes / (line_bytes * ways);
  endfunction

endpackage

// File: rtl/war_head_tracker.sv
module war_head_tracker #(
  parameter int DEPTH = 8,
  parameter int PTR_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_pop,
  output logic [PTR_W-1:0] head
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] head_q;
  logic [PTR_W-1:0] head_next;

  always_comb begin
    head_next = head_q;
    if (rd_pop) begin
      if (head_q == LAST) head_next = '0;
      else                head_next = head_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) head_q <= '0;
    else     head_q <= head_next;
  end

  assign head = head_q;
endmodule

// File: rtl/war_hazard_lane.sv
module war_hazard_lane
  import war_hazard_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int PTR_W = 3,
  parameter int IDX_W = 7,
  parameter int SLOT  = 0
) (
  input  logic             slot_valid,
  input  logic [IDX_W-1:0] slot_index,
  input  logic             wq_valid,
  input  logic [IDX_W-1:0] wq_index,
  input  logic [PTR_W-1:0] wq_slot,
  input  logic [PTR_W-1:0] head,
  input  logic             rd_pop,
  output logic             idx_hit,
  output logic             is_older,
  output logic             retiring,
  output logic             hazard
);
  localparam logic [PTR_W-1:0] MY_SLOT = PTR_W'(SLOT);

  assign idx_hit  = slot_valid && (slot_index == wq_index);
  assign is_older = queued_before(32'(SLOT), 32'(wq_slot), 32'(head), 32'(DEPTH));
  assign retiring = rd_pop && (head == MY_SLOT);
  assign hazard   = wq_valid && idx_hit && is_older && !retiring;
endmodule

// File: rtl/war_stall_reduce.sv
module war_stall_reduce #(
  parameter int DEPTH = 8
) (
  input  logic [DEPTH-1:0] hazard,
  output logic             stall
);
  always_comb begin
    stall = 1'b0;
    for (int i = 0; i < DEPTH; i++) stall = stall | hazard[i];
  end
endmodule

// File: rtl/war_hazard_guard.sv
module war_hazard_guard
  import war_hazard_pkg::*;
#(
  parameter int DEPTH       = 8,
  parameter int CACHE_BYTES = 16384,
  parameter int LINE_BYTES  = 32,
  parameter int WAYS        = 4,
  localparam int SETS       = int'(set_count(CACHE_BYTES, LINE_BYTES, WAYS)),
  localparam int IDX_W      = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int PTR_W      = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [DEPTH-1:0]       rq_valid,
  input  logic [DEPTH*IDX_W-1:0] rq_index,
  input  logic                   rd_pop,
  input  logic                   wq_valid,
  input  logic [IDX_W-1:0]       wq_index,
  input  logic [PTR_W-1:0]       wq_slot,
  output logic [DEPTH-1:0]       hazard,
  output logic                   stall_write
);
  logic [PTR_W-1:0] head_ptr;
  logic [DEPTH-1:0] lane_hit;
  logic [DEPTH-1:0] lane_older;
  logic [DEPTH-1:0] lane_retire;

  war_head_tracker #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_head (
    .clk(clk), .rst(rst), .rd_pop(rd_pop), .head(head_ptr)
  );

  for (genvar g = 0; g < DEPTH; g++) begin : g_lane
    war_hazard_lane #(
      .DEPTH(DEPTH), .PTR_W(PTR_W), .IDX_W(IDX_W), .SLOT(g)
    ) u_lane (
      .slot_valid (rq_valid[g]),
      .slot_index (rq_index[g*IDX_W +: IDX_W]),
      .wq_valid   (wq_valid),
      .wq_index   (wq_index),
      .wq_slot    (wq_slot),
      .head       (head_ptr),
      .rd_pop     (rd_pop),
      .idx_hit    (lane_hit[g]),
      .is_older   (lane_older[g]),
      .retiring   (lane_retire[g]),
      .hazard     (hazard[g])
    );
  end

  war_stall_reduce #(.DEPTH(DEPTH)) u_reduce (
    .hazard(hazard), .stall(stall_write)
  );
endmodule

// File: rtl/war_hazard_checker.sv
module war_hazard_checker #(
  parameter int DEPTH = 8,
  parameter int PTR_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             rd_pop,
  input logic             wq_valid,
  input logic [PTR_W-1:0] wq_slot,
  input logic [DEPTH-1:0] rq_valid,
  input logic [DEPTH-1:0] hazard,
  input logic             stall_write,
  input logic [PTR_W-1:0] head
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  assert_stall_any_R7: assert property (@(posedge clk) disable iff (rst)
    stall_write == (hazard != '0));

  assert_invalid_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    (hazard & ~rq_valid) == '0);

  assert_no_fill_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    !wq_valid |-> (hazard == '0 && !stall_write));

  assert_miss_slot_clear_R5: assert property (@(posedge clk) disable iff (rst)
    wq_valid |-> !hazard[wq_slot]);

  assert_pop_mask_R8: assert property (@(posedge clk) disable iff (rst)
    rd_pop |-> !hazard[head]);

  assert_head_only_R10: assert property (@(posedge clk) disable iff (rst)
    (wq_slot == head) |-> hazard == '0);

  assert_head_step_R9: assert property (@(posedge clk) disable iff (rst)
    rd_pop |=> head == (($past(head) == LAST) ? '0 : $past(head) + 1'b1));

  assert_head_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !rd_pop |=> $stable(head));
endmodule

bind war_hazard_guard war_hazard_checker #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst(rst), .rd_pop(rd_pop), .wq_valid(wq_valid), .wq_slot(wq_slot),
  .rq_valid(rq_valid), .hazard(hazard), .stall_write(stall_write), .head(head_ptr)
);

// File: tb/sim_war_hazard_guard.sv
module sim_war_hazard_guard;
  localparam int CLK_PERIOD = 10;
  localparam int D  = 4;
  localparam int IW = 2;
  localparam int PW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [D-1:0]  rq_valid = '0;
  logic [D*IW-1:0] rq_index = '0;
  logic          rd_pop = 1'b0;
  logic          wq_valid = 1'b0;
  logic [IW-1:0] wq_index = '0;
  logic [PW-1:0] wq_slot = '0;
  logic [D-1:0]  hazard;
  logic          stall_write;

  int tests = 0;
  int fails = 0;
  int head_m = 0;
  bit done = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  war_hazard_guard #(.DEPTH(D), .CACHE_BYTES(256), .LINE_BYTES(16), .WAYS(4)) u0 (
    .clk(clk), .rst(rst), .rq_valid(rq_valid), .rq_index(rq_index), .rd_pop(rd_pop),
    .wq_valid(wq_valid), .wq_index(wq_index), .wq_slot(wq_slot),
    .hazard(hazard), .stall_write(stall_write)
  );

  // Walk forward from the head; slot i is older than s if reached before s.
  function automatic bit older_walk(int i, int h, int s);
    int k = h;
    for (int n = 0; n < D; n++) begin
      if (k == s) return 1'b0;
      if (k == i) return 1'b1;
      k = (k + 1) % D;
    end
    return 1'b0;
  endfunction

  function automatic logic [D-1:0] expect_vec();
    logic [D-1:0] e = '0;
    for (int i = 0; i < D; i++)
      e[i] = wq_valid && rq_valid[i] && (rq_index[i*IW +: IW] == wq_index) &&
             older_walk(i, head_m, int'(wq_slot)) && !(rd_pop && i == head_m);
    return e;
  endfunction

  function automatic string tag_for(int i);
    if (!wq_valid) return "R6";
    if (!rq_valid[i]) return "R3";
    if (rq_index[i*IW +: IW] != wq_index) return "R2";
    if (int'(wq_slot) == head_m) return "R10";
    if (rd_pop && i == head_m) return "R8";
    if (!older_walk(i, head_m, int'(wq_slot))) return "R5";
    return "R4";
  endfunction

  task automatic check_now(string extra);
    logic [D-1:0] e = expect_vec();
    for (int i = 0; i < D; i++) begin
      tests++;
      if (hazard[i] !== e[i]) begin
        fails++;
        $display("FAIL %s %s slot %0d head %0d: got %b exp %b",
                 tag_for(i), extra, i, head_m, hazard[i], e[i]);
      end
    end
    tests++;
    if (stall_write !== (e != '0)) begin
      fails++;
      $display("FAIL R7 %s stall: got %b exp %b", extra, stall_write, (e != '0));
    end
  endtask

  // Drive after the falling edge, check, then let the rising edge apply pops.
  task automatic apply_cycle(string extra);
    #2;
    check_now(extra);
    @(posedge clk);
    if (rd_pop) head_m = (head_m + 1) % D;
    @(negedge clk);
  endtask

  task automatic next_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    tests++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    head_m = 0;

    // R1: empty queue after reset, then slot 0 must act as oldest.
    apply_cycle("R1 empty");
    rq_valid = 4'b0011; rq_index = '0; wq_valid = 1'b1; wq_index = '0; wq_slot = 2'd1;
    #2;
    tests++;
    if (hazard !== 4'b0001) begin
      fails++; $display("FAIL R1 head at slot 0: got %b exp %b", hazard, 4'b0001);
    end
    @(negedge clk);

    // R9: three pops move head to slot 3; slot 3 then older than slot 0.
    rq_valid = '0; wq_valid = 1'b0;
    rd_pop = 1'b1;
    for (int k = 0; k < 3; k++) apply_cycle("R9 pop");
    rd_pop = 1'b0;
    rq_valid = 4'b1001; wq_valid = 1'b1; wq_slot = 2'd0;
    #2;
    tests++;
    if (hazard !== 4'b1000) begin
      fails++; $display("FAIL R9 head step: got %b exp %b", hazard, 4'b1000);
    end
    @(negedge clk);

    // Sweep: valid mask, miss slot, fill index, pop strobe; indices pseudo-random.
    for (int vm = 0; vm < 16; vm++)
      for (int sl = 0; sl < D; sl++)
        for (int wi = 0; wi < 4; wi++)
          for (int pp = 0; pp < 2; pp++) begin
            next_lfsr();
            rq_valid = 4'(vm);
            rq_index = lfsr[7:0];
            wq_valid = 1'b1;
            wq_index = 2'(wi);
            wq_slot  = 2'(sl);
            rd_pop   = pp[0];
            apply_cycle("sweep");
          end

    // R6: no pending fill, random everything else.
    for (int k = 0; k < 64; k++) begin
      next_lfsr();
      rq_valid = lfsr[3:0]; rq_index = lfsr[11:4]; wq_index = lfsr[13:12];
      wq_slot = lfsr[15:14]; rd_pop = lfsr[0]; wq_valid = 1'b0;
      apply_cycle("R6 idle");
    end

    // R1 again: mid-run reset returns the head to slot 0.
    rd_pop = 1'b1; wq_valid = 1'b0;
    apply_cycle("pre-reset");
    rd_pop = 1'b0; rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0; head_m = 0;
    rq_valid = 4'b0011; rq_index = '0; wq_valid = 1'b1; wq_index = '0; wq_slot = 2'd1;
    #2;
    tests++;
    if (hazard !== 4'b0001) begin
      fails++; $display("FAIL R1 reset head: got %b exp %b", hazard, 4'b0001);
    end
    @(negedge clk);

    finish_run();
  end
endmodule